// File: doc/BRIEF.md
# Radix Walk Entry Checker

This purely combinational block runs before a radix translation walk begins. It takes an effective address, the size of the tree's root, and the width of the root-level index. From these it decides whether the walk may start.

It flags a segment fault when the address lies outside the region the tree can map. It flags a malformed tree when the root index width is outside its legal window. When neither fault applies, it produces the shift that the first-level index extraction uses. A 44-bit run-of-ones mask generator, sized by the root size, is built in. The walker registers the outputs and branches on them.

Top module: `radix_entry_check`

## Requirements
- R1: `seg_fault` is 1 whenever address bits 63 and 62 differ. When both are 0 or both are 1 and no masked bit is set, this test does not raise a fault.
- R2: Bit 31+i of the address, for i from 0 to 30, raises `seg_fault` when it is 1 and i is not below `root_size`. Bit 31+i is ignored when i < `root_size`. Address bits 30 down to 0 never raise `seg_fault`.
- R3: Without a segment fault, `tree_bad` is 1 when `idx_bits` is below 5, above 16, or above `root_size` + 19.
- R4: Without any fault, `first_shift` equals the low 6 bits of `root_size` + 19 − `idx_bits`.
- R5: A segment fault takes priority: `tree_bad` is 0 whenever `seg_fault` is 1, even for an illegal `idx_bits`.
- R6: `first_shift` is 0 whenever `seg_fault` or `tree_bad` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ea | input | 64 | Effective address to be translated |
| root_size | input | 6 | Root size of the radix tree |
| idx_bits | input | 6 | Bit width of the root-level index |
| seg_fault | output | 1 | Address outside the mapped region |
| tree_bad | output | 1 | Root index width is illegal |
| first_shift | output | 6 | Shift for the first-level index extraction |

## Verification
The address patterns include all four combinations of the top two bits. They also set a single bit just inside and just outside the unmasked part of the checked window, for several root sizes. This separates a wrong mask length or polarity from a wrong window position. Index widths are tried at 4, 5, 16 and 17, which pins down both edges of the legal window. A root size of 63 checks that the shift is reduced modulo 64. A case with both faults present checks the priority of the segment fault.

// File: rtl/radix_entry_check.sv
module radix_entry_check #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned SHIFT_W = 6,
  parameter int unsigned MASK_W  = 44,
  parameter int unsigned WIN_LO  = 31,
  parameter int unsigned WIN_W   = 31,
  parameter int unsigned BIAS    = 19,
  parameter int unsigned IDX_MIN = 5,
  parameter int unsigned IDX_MAX = 16
) (
  input  logic [ADDR_W-1:0]  ea,
  input  logic [SHIFT_W-1:0] root_size,
  input  logic [SHIFT_W-1:0] idx_bits,
  output logic               seg_fault,
  output logic               tree_bad,
  output logic [SHIFT_W-1:0] first_shift
);
  localparam int unsigned WIN_HI = WIN_LO + WIN_W - 1;
  localparam int unsigned SUM_W  = SHIFT_W + 2;

  logic [MASK_W-1:0] run_mask;
  logic [WIN_W-1:0]  stray;
  logic              sign_split;
  logic              idx_illegal;
  logic [SUM_W-1:0]  limit;
  logic [SUM_W-1:0]  span;

  for (genvar g = 0; g < MASK_W; g++) begin : g_mask
    assign run_mask[g] = (32'(root_size) > g);
  end

  assign sign_split = ea[ADDR_W-1] ^ ea[ADDR_W-2];
  assign stray      = ea[WIN_HI:WIN_LO] & ~run_mask[WIN_W-1:0];
  assign seg_fault  = sign_split | (|stray);

  assign limit       = SUM_W'(root_size) + SUM_W'(BIAS);
  assign idx_illegal = (idx_bits < SHIFT_W'(IDX_MIN)) |
                       (idx_bits > SHIFT_W'(IDX_MAX)) |
                       (SUM_W'(idx_bits) > limit);
  assign tree_bad    = ~seg_fault & idx_illegal;

  assign span        = limit - SUM_W'(idx_bits);
  assign first_shift = (seg_fault | tree_bad) ? '0 : span[SHIFT_W-1:0];

  always_comb begin
    // R1
    sign_split_chk: assert (ea[ADDR_W-1] == ea[ADDR_W-2] || seg_fault);
    // R5
    fault_priority_chk: assert (!(seg_fault && tree_bad));
    // R6
    shift_cleared_chk: assert (!(seg_fault || tree_bad) || first_shift == '0);
    // R4
    shift_sum_chk: assert ((seg_fault || tree_bad) ||
      (SHIFT_W'(first_shift + idx_bits) == SHIFT_W'(32'(root_size) + BIAS)));
    // R3
    window_chk: assert (!tree_bad ||
      idx_bits < SHIFT_W'(IDX_MIN) || idx_bits > SHIFT_W'(IDX_MAX) ||
      32'(idx_bits) > 32'(root_size) + BIAS);
  end
endmodule

// File: tb/radix_entry_check_tb.sv
module radix_entry_check_tb;
  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic [63:0] ea;
  logic [5:0]  root_size, idx_bits, first_shift;
  logic        seg_fault, tree_bad;
  int errors = 0, checks = 0;
  bit done = 0;

  radix_entry_check u_dut (.ea(ea), .root_size(root_size), .idx_bits(idx_bits),
    .seg_fault(seg_fault), .tree_bad(tree_bad), .first_shift(first_shift));

  typedef struct packed {
    logic [63:0] a; logic [5:0] r; logic [5:0] i;
    logic s; logic b; logic [5:0] sh; logic [7:0] req;
  } vec_t;

  localparam int N = 20;
  localparam vec_t V [N] = '{
    '{64'h0000_0000_0000_1000, 6'd5,  6'd13, 1'b0, 1'b0, 6'd11, 8'd4},
    '{64'hC000_0000_0000_1000, 6'd5,  6'd13, 1'b0, 1'b0, 6'd11, 8'd1},
    '{64'h8000_0000_0000_0000, 6'd5,  6'd13, 1'b1, 1'b0, 6'd0,  8'd1},
    '{64'h4000_0000_0000_0000, 6'd5,  6'd13, 1'b1, 1'b0, 6'd0,  8'd1},
    '{64'h0000_0008_0000_0000, 6'd5,  6'd13, 1'b0, 1'b0, 6'd11, 8'd2},
    '{64'h0000_0010_0000_0000, 6'd5,  6'd13, 1'b1, 1'b0, 6'd0,  8'd2},
    '{64'h2000_0000_0000_0000, 6'd31, 6'd16, 1'b0, 1'b0, 6'd34, 8'd2},
    '{64'h2000_0000_0000_0000, 6'd30, 6'd16, 1'b1, 1'b0, 6'd0,  8'd2},
    '{64'h0000_0000_8000_0000, 6'd0,  6'd5,  1'b1, 1'b0, 6'd0,  8'd2},
    '{64'h0000_0000_8000_0000, 6'd1,  6'd5,  1'b0, 1'b0, 6'd15, 8'd2},
    '{64'h0000_0000_4000_0000, 6'd0,  6'd5,  1'b0, 1'b0, 6'd14, 8'd2},
    '{64'h0000_0000_0000_0000, 6'd5,  6'd4,  1'b0, 1'b1, 6'd0,  8'd3},
    '{64'h0000_0000_0000_0000, 6'd5,  6'd17, 1'b0, 1'b1, 6'd0,  8'd3},
    '{64'h0000_0000_0000_0000, 6'd5,  6'd5,  1'b0, 1'b0, 6'd19, 8'd3},
    '{64'h0000_0000_0000_0000, 6'd5,  6'd16, 1'b0, 1'b0, 6'd8,  8'd3},
    '{64'h0000_0000_0000_0000, 6'd0,  6'd16, 1'b0, 1'b0, 6'd3,  8'd4},
    '{64'h2000_0000_0000_0000, 6'd63, 6'd5,  1'b0, 1'b0, 6'd13, 8'd4},
    '{64'h8000_0000_0000_0000, 6'd5,  6'd4,  1'b1, 1'b0, 6'd0,  8'd5},
    '{64'h0000_0010_0000_0000, 6'd5,  6'd63, 1'b1, 1'b0, 6'd0,  8'd5},
    '{64'hFFFF_FFFF_FFFF_FFFF, 6'd0,  6'd0,  1'b1, 1'b0, 6'd0,  8'd6}
  };

  task automatic apply(input logic [63:0] a, input logic [5:0] r, input logic [5:0] i,
                       input logic s, input logic b, input logic [5:0] sh, input string tag);
    ea = a; root_size = r; idx_bits = i;
    @(negedge clk);
    checks++;
    if (seg_fault !== s || tree_bad !== b || first_shift !== sh) begin
      errors++;
      $display("FAIL %s: ea=%h rs=%0d ib=%0d got seg=%b bad=%b sh=%0d exp seg=%b bad=%b sh=%0d",
               tag, a, r, i, seg_fault, tree_bad, first_shift, s, b, sh);
    end
  endtask

  initial begin
    ea = '0; root_size = '0; idx_bits = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R3 idle inputs: zero index width is illegal, R6 shift cleared
    apply(64'h0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd0, "R3 R6 idle");
    for (int k = 0; k < N; k++)
      apply(V[k].a, V[k].r, V[k].i, V[k].s, V[k].b, V[k].sh, $sformatf("R%0d vec%0d", V[k].req, k));
    // R2 low address bits never fault
    apply(64'h0000_0000_7FFF_FFFF, 6'd0, 6'd9, 1'b0, 1'b0, 6'd10, "R2 low bits");
    // R1 both top bits set with full window permitted
    apply(64'hFFFF_FFFF_FFFF_FFFF, 6'd31, 6'd12, 1'b0, 1'b0, 6'd38, "R1 all ones");
    // R4 top edge of window at largest root size
    apply(64'h0, 6'd63, 6'd16, 1'b0, 1'b0, 6'd2, "R4 wrap");
    // R5 R6 segment fault hides legal index
    apply(64'h4000_0000_0000_0000, 6'd40, 6'd10, 1'b1, 1'b0, 6'd0, "R5 R6 priority");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); checks++; errors++; $display("FAIL watchdog expired"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule